// File: doc/BRIEF.md
# Interrupt Routing Register Window

This block holds the routing table of an interrupt controller and lets software reach it through two byte offsets. One offset is an 8-bit select register. The other is a 32-bit data window whose meaning depends on the select value. Through the window, software reaches a read-only version word, a 4-bit identification field and one 64-bit routing entry per interrupt pin. Each routing entry is transferred one 32-bit half at a time. The number of pins is a parameter and defaults to 24.

Every field of every entry is driven out continuously, so that neighbouring delivery logic can use it. The delivery logic sets an entry's remote-IRR flag through a per-pin pulse input, and a write to the lower half of that entry clears it. The block emits two one-cycle notification pulses: one when a write flips an entry's mask bit, and one for every accepted entry write. Delivering interrupts is left to other logic.

Software access uses a valid/ready request channel and a valid/ready read-response channel. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is low only while a read response is waiting and `rsp_ready` is low. A stalled response therefore holds back all further requests, reads and writes alike. Only reads produce a response.

Top module: `irq_route_regfile`

## Requirements
- R1: A write to offset 0x00 keeps bits 7:0 of the write data as the select value. A read of offset 0x00 returns that value zero-extended. Address bits 7:0 are decoded as the offset.
- R2: With select 0x01, a window read (offset 0x10) returns PINS-1 in bits 23:16 and the VERSION parameter (default 0x11) in bits 7:0, with every other bit 0. Window writes with this select change nothing.
- R3: With select 0x00, a window write stores data bits 27:24 as the ID. A window read with select 0x00 or 0x02 returns the ID in bits 27:24 and 0 elsewhere. Window writes with select 0x02 are ignored.
- R4: For select values of 0x10 and above, the entry index is (select-0x10)>>1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0. Written bits read back unchanged, apart from R6.
- R5: A window read returns 0xFFFFFFFF when the select is 0x03..0x0F or the entry index is at or beyond PINS. A window write in the same cases changes no entry and raises no pulse.
- R6: Remote-IRR is entry bit 14. A pulse on `rirr_set[i]` sets it in entry i. A lower-half write to entry i clears it, and the write wins over a set in the same cycle. An upper-half write leaves it unchanged.
- R7: After reset, every entry reads as 0x0000_0000_0001_0000 (only the mask, bit 16, set), and the select and ID are 0.
- R8: Reads of offsets other than 0x00 and 0x10 return 0. Writes to them are ignored.
- R9: The per-pin outputs show the stored entry at all times: vector bits 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-IRR 14, trigger mode 15, mask 16, destination 63:56.
- R10: In the cycle after a lower-half write that changes an entry's mask bit, `mchg_valid` is high for one cycle, with the pin and the new mask value. A write that leaves the mask unchanged produces no pulse.
- R11: In the cycle after each accepted in-range entry write, `ewr_valid` is high for one cycle, with the pin and whether the upper half was written.
- R12: `req_ready` = !`rsp_valid` || `rsp_ready`. A read taken at an edge has its response valid from that edge on. The response holds its data unchanged until it is taken with `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Read data taken |
| rsp_data | output | 32 | Read data |
| rirr_set | input | PINS | Per-pin remote-IRR set pulse |
| vec_o | output | PINS*8 | Vector of each pin |
| dlv_o | output | PINS*3 | Delivery mode of each pin |
| dmode_o | output | PINS | Destination mode of each pin |
| pol_o | output | PINS | Polarity of each pin |
| rirr_o | output | PINS | Remote-IRR of each pin |
| trig_o | output | PINS | Trigger mode of each pin |
| mask_o | output | PINS | Mask of each pin |
| dest_o | output | PINS*8 | Destination of each pin |
| mchg_valid | output | 1 | Mask change pulse |
| mchg_pin | output | IDXW | Pin whose mask changed |
| mchg_val | output | 1 | New mask value |
| ewr_valid | output | 1 | Entry write pulse |
| ewr_pin | output | IDXW | Pin written |
| ewr_upper | output | 1 | Upper half was written |

## Verification
A request driven before a rising edge is taken at that edge when `req_ready` is high. Its effects then appear one register later, all at that same edge: the read response, the updated select, ID and field outputs, and the mask-change and entry-write pulses. `req_ready` itself follows `rsp_ready` within the same cycle. The bench advances a behavioural model at each rising edge from the inputs it drove, and compares every output at the following falling edge. That is the point where all of these results are due and settled. Because inputs change only just after a falling edge, the model and the design always see the same stimulus.

// File: rtl/irq_rw_pkg.sv
package irq_rw_pkg;
  localparam logic [7:0] OFS_SELECT   = 8'h00;
  localparam logic [7:0] OFS_WINDOW   = 8'h10;
  localparam logic [7:0] SEL_ID       = 8'h00;
  localparam logic [7:0] SEL_VER      = 8'h01;
  localparam logic [7:0] SEL_ARB      = 8'h02;
  localparam logic [7:0] SEL_TBL_BASE = 8'h10;

  localparam int B_VEC  = 0;
  localparam int B_DLV  = 8;
  localparam int B_DMOD = 11;
  localparam int B_POL  = 13;
  localparam int B_RIRR = 14;
  localparam int B_TRIG = 15;
  localparam int B_MASK = 16;
  localparam int B_DEST = 56;

  typedef enum logic [2:0] {
    AK_SELECT, AK_ID, AK_VERSION, AK_ARB, AK_ENTRY, AK_VOID, AK_OTHER
  } acc_kind_t;
endpackage

// File: rtl/irq_rw_decode.sv
module irq_rw_decode
  import irq_rw_pkg::*;
#(
  parameter int PINS = 24,
  parameter int IDXW = 5
) (
  input  logic [7:0]      addr,
  input  logic [7:0]      sel,
  output acc_kind_t       kind,
  output logic [IDXW-1:0] idx,
  output logic            upper
);
  logic [6:0] raw;

  always_comb begin
    raw   = sel[7:1] - 7'd8;
    idx   = raw[IDXW-1:0];
    upper = sel[0];
    if (addr == OFS_SELECT)                             kind = AK_SELECT;
    else if (addr != OFS_WINDOW)                        kind = AK_OTHER;
    else if (sel == SEL_ID)                             kind = AK_ID;
    else if (sel == SEL_VER)                            kind = AK_VERSION;
    else if (sel == SEL_ARB)                            kind = AK_ARB;
    else if (sel < SEL_TBL_BASE || 32'(raw) >= PINS)    kind = AK_VOID;
    else                                                kind = AK_ENTRY;
  end
endmodule

// File: rtl/irq_rw_entry.sv
module irq_rw_entry
  import irq_rw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  output logic [63:0] ent
);
  localparam logic [63:0] RST_VAL = 64'(1) << B_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent <= RST_VAL;
    end else begin
      if (rirr_set) ent[B_RIRR] <= 1'b1;
      if (wr_hi)    ent[63:32]  <= wdata;
      if (wr_lo) begin
        ent[31:0]   <= wdata;
        ent[B_RIRR] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
  import irq_rw_pkg::*;
#(
  parameter int          PINS    = 24,
  parameter logic [7:0]  VERSION = 8'h11,
  localparam int         IDXW    = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [7:0]         req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_data,
  input  logic [PINS-1:0]    rirr_set,
  output logic [PINS*8-1:0]  vec_o,
  output logic [PINS*3-1:0]  dlv_o,
  output logic [PINS-1:0]    dmode_o,
  output logic [PINS-1:0]    pol_o,
  output logic [PINS-1:0]    rirr_o,
  output logic [PINS-1:0]    trig_o,
  output logic [PINS-1:0]    mask_o,
  output logic [PINS*8-1:0]  dest_o,
  output logic               mchg_valid,
  output logic [IDXW-1:0]    mchg_pin,
  output logic               mchg_val,
  output logic               ewr_valid,
  output logic [IDXW-1:0]    ewr_pin,
  output logic               ewr_upper
);
  logic [7:0]      sel_q;
  logic [3:0]      id_q;
  logic [63:0]     tbl [PINS];
  acc_kind_t       kind;
  logic [IDXW-1:0] idx;
  logic            upper;
  logic            acc, wr, rd, entry_hit;
  logic [31:0]     rd_word;

  irq_rw_decode #(.PINS(PINS), .IDXW(IDXW)) u_dec (
    .addr (req_addr),
    .sel  (sel_q),
    .kind (kind),
    .idx  (idx),
    .upper(upper)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr        = acc && req_write;
  assign rd        = acc && !req_write;
  assign entry_hit = wr && (kind == AK_ENTRY);

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic sel_me;
    assign sel_me = entry_hit && (idx == IDXW'(g));
    irq_rw_entry u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (sel_me && !upper),
      .wr_hi   (sel_me && upper),
      .wdata   (req_wdata),
      .rirr_set(rirr_set[g]),
      .ent     (tbl[g])
    );
    assign vec_o[g*8 +: 8]  = tbl[g][B_VEC +: 8];
    assign dlv_o[g*3 +: 3]  = tbl[g][B_DLV +: 3];
    assign dmode_o[g]       = tbl[g][B_DMOD];
    assign pol_o[g]         = tbl[g][B_POL];
    assign rirr_o[g]        = tbl[g][B_RIRR];
    assign trig_o[g]        = tbl[g][B_TRIG];
    assign mask_o[g]        = tbl[g][B_MASK];
    assign dest_o[g*8 +: 8] = tbl[g][B_DEST +: 8];
  end

  always_comb begin
    case (kind)
      AK_SELECT:        rd_word = {24'd0, sel_q};
      AK_ID, AK_ARB:    rd_word = {4'd0, id_q, 24'd0};
      AK_VERSION:       rd_word = {8'd0, 8'(PINS - 1), 8'd0, VERSION};
      AK_ENTRY:         rd_word = upper ? tbl[idx][63:32] : tbl[idx][31:0];
      AK_VOID:          rd_word = '1;
      default:          rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr && kind == AK_SELECT) sel_q <= req_wdata[7:0];
      if (wr && kind == AK_ID)     id_q  <= req_wdata[27:24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mchg_valid <= 1'b0;
      mchg_pin   <= '0;
      mchg_val   <= 1'b0;
      ewr_valid  <= 1'b0;
      ewr_pin    <= '0;
      ewr_upper  <= 1'b0;
    end else begin
      mchg_valid <= entry_hit && !upper && (req_wdata[B_MASK] != tbl[idx][B_MASK]);
      mchg_pin   <= idx;
      mchg_val   <= req_wdata[B_MASK];
      ewr_valid  <= entry_hit;
      ewr_pin    <= idx;
      ewr_upper  <= upper;
    end
  end
endmodule

// File: rtl/irq_rw_checks.sv
module irq_rw_checks #(
  parameter int PINS = 24,
  parameter int IDXW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic [7:0]      req_addr,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [31:0]     rsp_data,
  input logic [PINS-1:0] mask_o,
  input logic [PINS-1:0] rirr_o,
  input logic            mchg_valid,
  input logic [IDXW-1:0] mchg_pin,
  input logic            mchg_val,
  input logic            ewr_valid,
  input logic [IDXW-1:0] ewr_pin,
  input logic            ewr_upper
);
  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R12
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R10
  mchg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mchg_valid |-> $past(req_valid && req_ready && req_write && req_addr == 8'h10));

  // R10
  mchg_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mchg_valid |-> (mask_o[mchg_pin] == mchg_val));

  // R6
  rirr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ewr_valid && !ewr_upper) |-> !rirr_o[ewr_pin]);

  // R5
  ewr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ewr_valid |-> (32'(ewr_pin) < PINS));
endmodule

bind irq_route_regfile irq_rw_checks #(.PINS(PINS), .IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .mask_o    (mask_o),
  .rirr_o    (rirr_o),
  .mchg_valid(mchg_valid),
  .mchg_pin  (mchg_pin),
  .mchg_val  (mchg_val),
  .ewr_valid (ewr_valid),
  .ewr_pin   (ewr_pin),
  .ewr_upper (ewr_upper)
);

// File: tb/irq_route_regfile_test.sv
`timescale 1ns/1ps
module irq_route_regfile_test;
  localparam int PINS = 24;
  localparam int IDXW = $clog2(PINS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [PINS-1:0] rirr_set = '0;
  logic req_ready, rsp_valid, mchg_valid, mchg_val, ewr_valid, ewr_upper;
  logic [31:0] rsp_data;
  logic [PINS*8-1:0] vec_o, dest_o;
  logic [PINS*3-1:0] dlv_o;
  logic [PINS-1:0] dmode_o, pol_o, rirr_o, trig_o, mask_o;
  logic [IDXW-1:0] mchg_pin, ewr_pin;

  always #2.5 clk = ~clk;

  irq_route_regfile #(.PINS(PINS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rirr_set(rirr_set), .vec_o(vec_o), .dlv_o(dlv_o), .dmode_o(dmode_o),
    .pol_o(pol_o), .rirr_o(rirr_o), .trig_o(trig_o), .mask_o(mask_o),
    .dest_o(dest_o), .mchg_valid(mchg_valid), .mchg_pin(mchg_pin),
    .mchg_val(mchg_val), .ewr_valid(ewr_valid), .ewr_pin(ewr_pin),
    .ewr_upper(ewr_upper)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [63:0] m_tbl [PINS];
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  logic        m_rv, m_mv, m_mval, m_ev, m_eup;
  int          m_mpin, m_epin;
  logic [31:0] m_rd;
  string       m_tag;
  bit          last_acc;

  function automatic logic [31:0] mread(input logic [7:0] a, output string tag);
    int ix;
    if (a == 8'h00) begin tag = "R1"; return {24'd0, m_sel}; end
    if (a != 8'h10) begin tag = "R8"; return 32'd0; end
    if (m_sel == 8'h00 || m_sel == 8'h02) begin tag = "R3"; return {4'd0, m_id, 24'd0}; end
    if (m_sel == 8'h01) begin tag = "R2"; return {8'd0, 8'(PINS - 1), 8'd0, 8'h11}; end
    if (m_sel < 8'h10) begin tag = "R5"; return 32'hFFFF_FFFF; end
    ix = (int'(m_sel) - 16) / 2;
    if (ix >= PINS) begin tag = "R5"; return 32'hFFFF_FFFF; end
    tag = "R4 R6";
    return m_sel[0] ? m_tbl[ix][63:32] : m_tbl[ix][31:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PINS; i++) m_tbl[i] = 64'h1_0000;
      m_sel = 0; m_id = 0; m_rv = 0; m_mv = 0; m_ev = 0; m_rd = 0;
      m_mval = 0; m_eup = 0; m_mpin = 0; m_epin = 0; last_acc = 0; m_tag = "R12";
    end else begin
      bit acc;
      acc = req_valid && (!m_rv || rsp_ready);
      last_acc = acc;
      m_mv = 0; m_ev = 0;
      if (m_rv && rsp_ready) m_rv = 0;
      if (acc && !req_write) begin
        string t;
        m_rd = mread(req_addr, t);
        m_tag = t;
        m_rv = 1;
      end
      for (int i = 0; i < PINS; i++) if (rirr_set[i]) m_tbl[i][14] = 1'b1;
      if (acc && req_write) begin
        if (req_addr == 8'h00) m_sel = req_wdata[7:0];
        else if (req_addr == 8'h10) begin
          if (m_sel == 8'h00) m_id = req_wdata[27:24];
          else if (m_sel >= 8'h10 && (int'(m_sel) - 16) / 2 < PINS) begin
            int ix;
            ix = (int'(m_sel) - 16) / 2;
            m_ev = 1; m_epin = ix; m_eup = m_sel[0];
            if (m_sel[0]) m_tbl[ix][63:32] = req_wdata;
            else begin
              m_mv = (req_wdata[16] != m_tbl[ix][16]);
              m_mpin = ix; m_mval = req_wdata[16];
              m_tbl[ix][31:0] = req_wdata;
              m_tbl[ix][14] = 1'b0;
            end
          end
        end
      end
    end
  end

  // Compare every cycle at the falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [PINS*8-1:0] ev, ed;
      logic [PINS*3-1:0] edl;
      logic [PINS-1:0] edm, ep, er, et, em;
      for (int i = 0; i < PINS; i++) begin
        ev[i*8 +: 8] = m_tbl[i][7:0];
        ed[i*8 +: 8] = m_tbl[i][63:56];
        edl[i*3 +: 3] = m_tbl[i][10:8];
        edm[i] = m_tbl[i][11]; ep[i] = m_tbl[i][13]; er[i] = m_tbl[i][14];
        et[i] = m_tbl[i][15];  em[i] = m_tbl[i][16];
      end
      chk("R12 ready", 256'(req_ready), 256'(!m_rv || rsp_ready));
      chk("R12 valid", 256'(rsp_valid), 256'(m_rv));
      if (m_rv) chk({m_tag, " data"}, 256'(rsp_data), 256'(m_rd));
      chk("R9 vector", 256'(vec_o), 256'(ev));
      chk("R9 dest", 256'(dest_o), 256'(ed));
      chk("R9 fields", 256'({dlv_o, dmode_o, pol_o, trig_o, mask_o}), 256'({edl, edm, ep, et, em}));
      chk("R6 rirr", 256'(rirr_o), 256'(er));
      chk("R10 pulse", 256'(mchg_valid), 256'(m_mv));
      if (m_mv) chk("R10 pin/val", 256'({mchg_pin, mchg_val}), 256'({IDXW'(m_mpin), m_mval}));
      chk("R11 pulse", 256'(ewr_valid), 256'(m_ev));
      if (m_ev) chk("R11 pin/half", 256'({ewr_pin, ewr_upper}), 256'({IDXW'(m_epin), m_eup}));
    end
  end

  task automatic access(input bit w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    forever begin @(negedge clk); if (last_acc) break; end
    #1 req_valid = 0;
  endtask

  task automatic wsel(input logic [7:0] s);  access(1, 8'h00, {24'hFFFFFF, s}); endtask
  task automatic wwin(input logic [31:0] d); access(1, 8'h10, d); endtask
  task automatic rwin();                     access(0, 8'h10, 32'd0); endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R7 reset state at the ports
    chk("R7 mask", 256'(mask_o), 256'({PINS{1'b1}}));
    chk("R7 vector", 256'(vec_o), 256'd0);
    access(0, 8'h00, 0);                 // R1 select is 0
    rwin();                              // R3 id is 0
    wsel(8'h11); rwin();                 // R7 entry 0 upper
    wsel(8'h10); rwin();                 // R7 entry 0 lower
    // R1 only low 8 bits kept
    access(1, 8'h00, 32'hFFFF_FF37); access(0, 8'h00, 0);
    // R2 version and ignored write
    wsel(8'h01); rwin(); wwin(32'hFFFF_FFFF); rwin();
    // R3 id, arbitration alias, ignored arbitration write
    wsel(8'h00); wwin(32'hA500_0000); rwin();
    wsel(8'h02); rwin(); wwin(32'h0F00_0000); rwin();
    wsel(8'h00); rwin();
    // R4 R9 R10 R11 entries at several indices
    wsel(8'h10); wwin(32'h0000_A931); rwin();
    wsel(8'h11); wwin(32'h7F00_0000); rwin();
    wsel(8'h2E); wwin(32'h0000_2342); wwin(32'h0001_2343); wwin(32'h0001_2344);
    wsel(8'h2F); wwin(32'hC500_00AA); rwin();
    wsel(8'h12); wwin(32'h0000_8155); rwin();
    wsel(8'h28); wwin(32'h0000_6060);
    // R6 remote-IRR set, upper write keeps, lower write clears
    @(negedge clk); #1 rirr_set = 24'h00_0003;
    @(negedge clk); #1 rirr_set = 0;
    wsel(8'h10); rwin(); wsel(8'h11); wwin(32'h1100_0000); wsel(8'h10); rwin();
    wwin(32'h0000_A931); rwin();
    // R6 set and lower write in the same cycle: write wins
    wsel(8'h12);
    @(negedge clk); #1;
    rirr_set = 24'h00_0002; req_valid = 1; req_write = 1; req_addr = 8'h10; req_wdata = 32'h0000_4066;
    @(negedge clk); #1 rirr_set = 0; req_valid = 0;
    rwin();
    // R5 out of range
    wsel(8'h40); rwin(); wwin(32'h0000_0000);
    wsel(8'h41); rwin(); wwin(32'hDEAD_BEEF);
    wsel(8'h05); rwin(); wwin(32'h0000_0000);
    wsel(8'hFF); rwin();
    // R8 other offsets
    access(0, 8'h04, 0); access(0, 8'h20, 0); access(0, 8'hF0, 0);
    access(1, 8'h20, 32'h0000_0000); access(1, 8'h08, 32'h0000_0000);
    wsel(8'h00); rwin();
    // R12 back-pressure
    @(negedge clk); #1 rsp_ready = 0;
    access(0, 8'h00, 0);
    fork
      rwin();
      begin repeat (4) @(negedge clk); #1 rsp_ready = 1; end
    join
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule